// File: doc/BRIEF.md
# Parser Lookup Key Builder

This block assembles the two lookup keys that a programmable packet-header parser needs in every parse round. The first is a byte-wide match key: its top byte is either the low byte of the type-selector register or an immediate priority byte, and its remaining bytes are a window of packet bytes starting at the current header offset, stored in reversed order. The second is a parse-graph key made of a 32-bit next-protocol value, four optionally-sampled flag bits, one register chosen by index and the current node number.

The next-protocol value comes from a small builder with three operations: a bit-field extract from a 32-byte header window, a concatenation of two registers, and a constant zero. The header window is a registered copy of the packet bytes at the header offset, refreshed only when the parser announces a header-offset write. A reserved operation code aborts the round: no key is presented and an error strobe pulses instead. Matching the keys against any table is done elsewhere.

A round is requested by pulsing `start`; the keys appear on the registered outputs one clock later together with `key_vld`. Between rounds, and after an aborted round, the key outputs hold their last values.

Top module: `plk_key_builder`

## Requirements
- R1: The top match-key byte (`mkey[8*KEY_BYTES-1 -: 8]`) equals bits 7:0 of the type-selector register when `tsel_en` is 1, and `prio` when `tsel_en` is 0.
- R2: Match-key byte i (bits [8i+7:8i]) for i from KEY_BYTES-2 down to 0 holds packet byte number (header offset + KEY_BYTES-2-i); packet byte n sits at `pkt_flat[8n+7:8n]`.
- R3: A packet byte index at or beyond PKT_BYTES contributes the value zero to the match key and to the header window.
- R4: With `np_op`=0 (extract) the next-protocol value is the field of L bits starting at bit position `np_fa` of the header window, first bit as MSB, zero-extended, where L = `np_fb` clamped to 32; the window is read as a bit stream in which window byte k (packet byte offset+k) supplies stream bits 8k..8k+7, most significant bit first, and bits past the window read as zero.
- R5: With `np_op`=1 (build) the next-protocol value is register `np_fb` in bits 31:16 and register `np_fa` in bits 15:0 (register indices taken from the low bits of each field).
- R6: With `np_op`=2 (bypass) the next-protocol value is zero.
- R7: A `start` with `np_op`=3 produces a one-cycle `key_err` pulse, no `key_vld`, and leaves every key output unchanged.
- R8: Flag key bit n is 0 when `flag_en[n]` is 0; otherwise it is flag number f=`flag_idx[6n+5:6n]`, which is bit f%16 of register FLAG_BASE+f/16.
- R9: The node field always equals the next-node register, and the ALU-register field equals register `alu_idx`.
- R10: After reset all outputs are zero; keys of a round appear on the clock edge after the `start` edge with a one-cycle `key_vld`, and outputs hold when no valid round completes.
- R11: The header window is reloaded from the packet at the current header offset only on a clock edge with `hv_load` high; a round started on that same edge still sees the previous window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one key-building round |
| regs_flat | input | NUM_REGS*REG_W | Parser register file, register r at bits [r*REG_W +: REG_W] |
| pkt_flat | input | PKT_BYTES*8 | Packet byte buffer |
| hv_load | input | 1 | Header-offset write: reload the header window |
| tsel_en | input | 1 | Top key byte from type-selector register |
| prio | input | 8 | Immediate priority byte |
| np_op | input | 2 | Next-protocol operation |
| np_fa | input | 8 | Extract start bit or first register index |
| np_fb | input | 8 | Extract length or second register index |
| flag_en | input | NUM_FLAG_SEL | Flag-key sample enables |
| flag_idx | input | NUM_FLAG_SEL*FIW | Flag numbers, 6 bits each by default |
| alu_idx | input | RIDX_W | Register index for the ALU-register field |
| mkey | output | KEY_BYTES*8 | Match key |
| pg_next_proto | output | 32 | Next-protocol key field |
| pg_flags | output | NUM_FLAG_SEL | Sampled flag key bits |
| pg_alu_reg | output | REG_W | Selected register value |
| pg_node | output | REG_W | Current node number |
| key_vld | output | 1 | Keys of a completed round are present |
| key_err | output | 1 | Round aborted on a reserved operation |

## Verification
The assertions assume `start` and `np_op` are driven low or to a defined code from reset onward and are stable around each rising edge, so that the previous-cycle values they consult are the ones the design actually captured. The stimulus drives every input only on the falling edge, holds `start` low throughout reset, and mixes directed rounds (offsets near and past the packet end, extract fields crossing word boundaries, oversized lengths, reserved codes, window reloads without a round) with pseudo-random rounds whose header offset stays within a small range around the packet length.

// File: rtl/plk_pkg.sv
package plk_pkg;

   // next-protocol builder operations
   typedef enum logic [1:0] {
      NP_EXTRACT = 2'd0,
      NP_BUILD   = 2'd1,
      NP_BYPASS  = 2'd2,
      NP_RSVD    = 2'd3
   } np_op_e;

   localparam int PROTO_W     = 32;
   localparam int SEL_FIELD_W = 8;
   localparam int MAX_EXT_LEN = 32;

endpackage

// File: rtl/plk_byte_fetch.sv
// Returns one packet byte for a position, zero when the position lies past the buffer.
module plk_byte_fetch #(
   parameter int PKT_BYTES = 64,
   parameter int POS_W     = 17,
   localparam int PKT_BITS = PKT_BYTES * 8
) (
   input  logic [POS_W-1:0]    pos,
   input  logic [PKT_BITS-1:0] pkt_flat,
   output logic [7:0]          data
);

   logic [PKT_BITS-1:0] shifted;

   assign shifted = pkt_flat >> {pos, 3'b000};
   assign data    = (pos < POS_W'(PKT_BYTES)) ? shifted[7:0] : 8'h00;

endmodule

// File: rtl/plk_match_key.sv
// Byte-wide match key: selectable top byte, packet window below in reversed order.
module plk_match_key #(
   parameter int KEY_BYTES = 8,
   parameter int PKT_BYTES = 64,
   parameter int OFS_W     = 16,
   localparam int PKT_BITS = PKT_BYTES * 8,
   localparam int KEY_W    = KEY_BYTES * 8
) (
   input  logic [OFS_W-1:0]    ofs,
   input  logic [PKT_BITS-1:0] pkt_flat,
   input  logic                tsel_en,
   input  logic [7:0]          tsel_byte,
   input  logic [7:0]          prio,
   output logic [KEY_W-1:0]    key
);

   localparam int LOW_BYTES = KEY_BYTES - 1;

   assign key[KEY_W-1 -: 8] = tsel_en ? tsel_byte : prio;

   for (genvar gi = 0; gi < LOW_BYTES; gi++) begin : g_low
      logic [OFS_W:0] pos;
      logic [7:0]     byte_val;

      // key byte gi reads further into the packet the lower it sits
      assign pos = {1'b0, ofs} + (OFS_W + 1)'(LOW_BYTES - 1 - gi);

      plk_byte_fetch #(
         .PKT_BYTES(PKT_BYTES),
         .POS_W    (OFS_W + 1)
      ) u_fetch (
         .pos     (pos),
         .pkt_flat(pkt_flat),
         .data    (byte_val)
      );

      assign key[gi*8 +: 8] = byte_val;
   end

endmodule

// File: rtl/plk_hdr_window.sv
// Registered header window; byte 0 of the window is stored at the MSB end so the
// vector reads as a network-order bit stream.
module plk_hdr_window #(
   parameter int PKT_BYTES = 64,
   parameter int HV_BYTES  = 32,
   parameter int OFS_W     = 16,
   localparam int PKT_BITS = PKT_BYTES * 8,
   localparam int HV_BITS  = HV_BYTES * 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [OFS_W-1:0]    ofs,
   input  logic [PKT_BITS-1:0] pkt_flat,
   output logic [HV_BITS-1:0]  hv_stream
);

   logic [HV_BITS-1:0] win_next;

   for (genvar gk = 0; gk < HV_BYTES; gk++) begin : g_win
      logic [OFS_W:0] pos;
      logic [7:0]     byte_val;

      assign pos = {1'b0, ofs} + (OFS_W + 1)'(gk);

      plk_byte_fetch #(
         .PKT_BYTES(PKT_BYTES),
         .POS_W    (OFS_W + 1)
      ) u_fetch (
         .pos     (pos),
         .pkt_flat(pkt_flat),
         .data    (byte_val)
      );

      assign win_next[(HV_BYTES-1-gk)*8 +: 8] = byte_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hv_stream <= '0;
      end else if (load) begin
         hv_stream <= win_next;
      end
   end

endmodule

// File: rtl/plk_proto_builder.sv
// Next-protocol field: window extract, register concatenation or zero.
module plk_proto_builder
   import plk_pkg::*;
#(
   parameter int REG_W    = 16,
   parameter int NUM_REGS = 32,
   parameter int HV_BYTES = 32,
   localparam int HV_BITS = HV_BYTES * 8,
   localparam int RIDX_W  = $clog2(NUM_REGS),
   localparam int LEN_W   = $clog2(MAX_EXT_LEN) + 1
) (
   input  logic [1:0]                op,
   input  logic [SEL_FIELD_W-1:0]    fa,
   input  logic [SEL_FIELD_W-1:0]    fb,
   input  logic [HV_BITS-1:0]        hv_stream,
   input  logic [NUM_REGS*REG_W-1:0] regs_flat,
   output logic [PROTO_W-1:0]        proto,
   output logic                      illegal
);

   np_op_e op_e;
   assign op_e = np_op_e'(op);

   // extract path
   logic [HV_BITS-1:0] hv_sh;
   logic [PROTO_W-1:0] head;
   logic [LEN_W-1:0]   eff_len;
   logic [LEN_W-1:0]   rsh;
   logic [PROTO_W-1:0] ext_val;

   assign hv_sh   = hv_stream << fa;
   assign head    = hv_sh[HV_BITS-1 -: PROTO_W];
   assign eff_len = (fb > SEL_FIELD_W'(MAX_EXT_LEN)) ? LEN_W'(MAX_EXT_LEN) : fb[LEN_W-1:0];
   assign rsh     = LEN_W'(MAX_EXT_LEN) - eff_len;
   assign ext_val = head >> rsh;

   // build path
   logic [RIDX_W-1:0] ra;
   logic [RIDX_W-1:0] rb;
   logic [REG_W-1:0]  lo_word;
   logic [REG_W-1:0]  hi_word;

   assign ra      = fa[RIDX_W-1:0];
   assign rb      = fb[RIDX_W-1:0];
   assign lo_word = regs_flat[ra*REG_W +: REG_W];
   assign hi_word = regs_flat[rb*REG_W +: REG_W];

   always_comb begin
      proto   = '0;
      illegal = 1'b0;
      unique case (op_e)
         NP_EXTRACT: proto = ext_val;
         NP_BUILD:   proto = {hi_word, lo_word};
         NP_BYPASS:  proto = '0;
         default:    illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/plk_flag_pick.sv
// Samples enabled flag bits out of the flag register group.
module plk_flag_pick #(
   parameter int REG_W      = 16,
   parameter int NUM_REGS   = 32,
   parameter int FLAG_BASE  = 8,
   parameter int FLAG_WORDS = 4,
   parameter int NUM_SEL    = 4,
   localparam int FLAG_BITS = FLAG_WORDS * REG_W,
   localparam int FIW       = $clog2(FLAG_BITS)
) (
   input  logic [NUM_REGS*REG_W-1:0] regs_flat,
   input  logic [NUM_SEL-1:0]        en,
   input  logic [NUM_SEL*FIW-1:0]    idx,
   output logic [NUM_SEL-1:0]        bits
);

   localparam int BIT_W = $clog2(REG_W);
   localparam int WRD_W = (FIW > BIT_W) ? FIW - BIT_W : 1;

   for (genvar gs = 0; gs < NUM_SEL; gs++) begin : g_sel
      logic [FIW-1:0]   fi;
      logic [WRD_W-1:0] word;
      logic [BIT_W-1:0] bitpos;
      logic [REG_W-1:0] flag_word;

      assign fi        = idx[gs*FIW +: FIW];
      assign word      = WRD_W'(fi >> BIT_W);
      assign bitpos    = fi[BIT_W-1:0];
      assign flag_word = regs_flat[(FLAG_BASE + 32'(word))*REG_W +: REG_W];
      assign bits[gs]  = en[gs] & flag_word[bitpos];
   end

endmodule

// File: rtl/plk_key_builder.sv
// Top: forms match key and parse-graph key, registers them for one cycle.
module plk_key_builder
   import plk_pkg::*;
#(
   parameter int REG_W        = 16,
   parameter int NUM_REGS     = 32,
   parameter int PKT_BYTES    = 64,
   parameter int KEY_BYTES    = 8,
   parameter int HV_BYTES     = 32,
   parameter int NUM_FLAG_SEL = 4,
   parameter int FLAG_BASE    = 8,
   parameter int FLAG_WORDS   = 4,
   parameter int REG_TSEL     = 1,
   parameter int REG_HO       = 2,
   parameter int REG_NODE     = 3,
   localparam int RIDX_W      = $clog2(NUM_REGS),
   localparam int FIW         = $clog2(FLAG_WORDS * REG_W),
   localparam int KEY_W       = KEY_BYTES * 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [NUM_REGS*REG_W-1:0]     regs_flat,
   input  logic [PKT_BYTES*8-1:0]        pkt_flat,
   input  logic                          hv_load,
   input  logic                          tsel_en,
   input  logic [7:0]                    prio,
   input  logic [1:0]                    np_op,
   input  logic [7:0]                    np_fa,
   input  logic [7:0]                    np_fb,
   input  logic [NUM_FLAG_SEL-1:0]       flag_en,
   input  logic [NUM_FLAG_SEL*FIW-1:0]   flag_idx,
   input  logic [RIDX_W-1:0]             alu_idx,
   output logic [KEY_W-1:0]              mkey,
   output logic [31:0]                   pg_next_proto,
   output logic [NUM_FLAG_SEL-1:0]       pg_flags,
   output logic [REG_W-1:0]              pg_alu_reg,
   output logic [REG_W-1:0]              pg_node,
   output logic                          key_vld,
   output logic                          key_err
);

   localparam int HV_BITS = HV_BYTES * 8;

   // elaboration-time parameter checks
   if (REG_W != 16) begin : g_bad_regw
      $error("plk_key_builder: REG_W must be 16 so two registers fill the protocol field");
   end
   if ((1 << RIDX_W) != NUM_REGS || RIDX_W > SEL_FIELD_W) begin : g_bad_nregs
      $error("plk_key_builder: NUM_REGS must be a power of two addressable by an 8-bit field");
   end
   if (KEY_BYTES < 2) begin : g_bad_key
      $error("plk_key_builder: KEY_BYTES must be at least 2");
   end
   if (HV_BYTES < 4 || HV_BYTES > 32) begin : g_bad_hv
      $error("plk_key_builder: HV_BYTES must lie in 4..32");
   end
   if ((FLAG_WORDS & (FLAG_WORDS - 1)) != 0 || FLAG_BASE + FLAG_WORDS > NUM_REGS) begin : g_bad_flags
      $error("plk_key_builder: flag group must be a power of two and fit the register file");
   end
   if (REG_TSEL >= NUM_REGS || REG_HO >= NUM_REGS || REG_NODE >= NUM_REGS) begin : g_bad_idx
      $error("plk_key_builder: fixed register index out of range");
   end

   // register-file taps
   logic [REG_W-1:0] ho_val;
   logic [7:0]       tsel_byte;
   logic [REG_W-1:0] node_val;
   logic [REG_W-1:0] alu_val;

   assign ho_val    = regs_flat[REG_HO*REG_W +: REG_W];
   assign tsel_byte = regs_flat[REG_TSEL*REG_W +: 8];
   assign node_val  = regs_flat[REG_NODE*REG_W +: REG_W];
   assign alu_val   = regs_flat[alu_idx*REG_W +: REG_W];

   // match key
   logic [KEY_W-1:0] mkey_d;

   plk_match_key #(
      .KEY_BYTES(KEY_BYTES),
      .PKT_BYTES(PKT_BYTES),
      .OFS_W    (REG_W)
   ) u_mkey (
      .ofs      (ho_val),
      .pkt_flat (pkt_flat),
      .tsel_en  (tsel_en),
      .tsel_byte(tsel_byte),
      .prio     (prio),
      .key      (mkey_d)
   );

   // header window
   logic [HV_BITS-1:0] hv_stream;

   plk_hdr_window #(
      .PKT_BYTES(PKT_BYTES),
      .HV_BYTES (HV_BYTES),
      .OFS_W    (REG_W)
   ) u_hv (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hv_load),
      .ofs      (ho_val),
      .pkt_flat (pkt_flat),
      .hv_stream(hv_stream)
   );

   // next-protocol field
   logic [PROTO_W-1:0] proto_d;
   logic               op_illegal;

   plk_proto_builder #(
      .REG_W   (REG_W),
      .NUM_REGS(NUM_REGS),
      .HV_BYTES(HV_BYTES)
   ) u_proto (
      .op       (np_op),
      .fa       (np_fa),
      .fb       (np_fb),
      .hv_stream(hv_stream),
      .regs_flat(regs_flat),
      .proto    (proto_d),
      .illegal  (op_illegal)
   );

   // flag key bits
   logic [NUM_FLAG_SEL-1:0] flags_d;

   plk_flag_pick #(
      .REG_W     (REG_W),
      .NUM_REGS  (NUM_REGS),
      .FLAG_BASE (FLAG_BASE),
      .FLAG_WORDS(FLAG_WORDS),
      .NUM_SEL   (NUM_FLAG_SEL)
   ) u_flags (
      .regs_flat(regs_flat),
      .en       (flag_en),
      .idx      (flag_idx),
      .bits     (flags_d)
   );

   // output stage
   logic round_ok;
   assign round_ok = start & ~op_illegal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mkey          <= '0;
         pg_next_proto <= '0;
         pg_flags      <= '0;
         pg_alu_reg    <= '0;
         pg_node       <= '0;
         key_vld       <= 1'b0;
         key_err       <= 1'b0;
      end else begin
         key_vld <= round_ok;
         key_err <= start & op_illegal;
         if (round_ok) begin
            mkey          <= mkey_d;
            pg_next_proto <= proto_d;
            pg_flags      <= flags_d;
            pg_alu_reg    <= alu_val;
            pg_node       <= node_val;
         end
      end
   end

endmodule

// File: rtl/plk_key_builder_chk.sv
module plk_key_builder_chk #(
   parameter int KEY_BYTES    = 8,
   parameter int REG_W        = 16,
   parameter int NUM_FLAG_SEL = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start,
   input logic [1:0]               np_op,
   input logic [NUM_FLAG_SEL-1:0]  flag_en,
   input logic [KEY_BYTES*8-1:0]   mkey,
   input logic [31:0]              pg_next_proto,
   input logic [NUM_FLAG_SEL-1:0]  pg_flags,
   input logic [REG_W-1:0]         pg_alu_reg,
   input logic [REG_W-1:0]         pg_node,
   input logic                     key_vld,
   input logic                     key_err
);

   // R7: a round either completes or aborts, never both
   a_r7_vld_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(key_vld && key_err));

   // R10: a valid strobe only follows a start
   a_r10_vld_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |-> $past(start));

   // R7: the error strobe only follows a start with the reserved code
   a_r7_err_after_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      key_err |-> ($past(start) && $past(np_op) == 2'd3));

   // R10, R7: without a valid round every key output holds
   a_r10_hold_unless_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !key_vld |-> ($stable(mkey) && $stable(pg_next_proto) && $stable(pg_flags)
                    && $stable(pg_alu_reg) && $stable(pg_node)));

   // R6: bypass rounds carry a zero protocol field
   a_r6_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (key_vld && $past(np_op) == 2'd2) |-> pg_next_proto == 32'd0);

   // R8: disabled flag selectors produce zero
   a_r8_disabled_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |-> ((pg_flags & ~$past(flag_en)) == '0));

endmodule

bind plk_key_builder plk_key_builder_chk #(
   .KEY_BYTES   (KEY_BYTES),
   .REG_W       (REG_W),
   .NUM_FLAG_SEL(NUM_FLAG_SEL)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .np_op        (np_op),
   .flag_en      (flag_en),
   .mkey         (mkey),
   .pg_next_proto(pg_next_proto),
   .pg_flags     (pg_flags),
   .pg_alu_reg   (pg_alu_reg),
   .pg_node      (pg_node),
   .key_vld      (key_vld),
   .key_err      (key_err)
);

// File: tb/tb_plk_key_builder.sv
module tb_plk_key_builder;

   localparam int NR  = 32;
   localparam int PB  = 64;
   localparam int KB  = 8;
   localparam int HB  = 32;
   localparam int FIW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              start = 1'b0;
   logic              hv_load = 1'b0;
   logic              tsel_en = 1'b0;
   logic [7:0]        prio = '0;
   logic [1:0]        np_op = '0;
   logic [7:0]        np_fa = '0;
   logic [7:0]        np_fb = '0;
   logic [3:0]        flag_en = '0;
   logic [4*FIW-1:0]  flag_idx = '0;
   logic [4:0]        alu_idx = '0;
   logic [NR*16-1:0]  regs_flat = '0;
   logic [PB*8-1:0]   pkt_flat = '0;

   logic [KB*8-1:0]   mkey;
   logic [31:0]       pg_next_proto;
   logic [3:0]        pg_flags;
   logic [15:0]       pg_alu_reg;
   logic [15:0]       pg_node;
   logic              key_vld;
   logic              key_err;

   plk_key_builder dut (
      .clk(clk), .rst_n(rst_n), .start(start), .regs_flat(regs_flat),
      .pkt_flat(pkt_flat), .hv_load(hv_load), .tsel_en(tsel_en), .prio(prio),
      .np_op(np_op), .np_fa(np_fa), .np_fb(np_fb), .flag_en(flag_en),
      .flag_idx(flag_idx), .alu_idx(alu_idx), .mkey(mkey),
      .pg_next_proto(pg_next_proto), .pg_flags(pg_flags), .pg_alu_reg(pg_alu_reg),
      .pg_node(pg_node), .key_vld(key_vld), .key_err(key_err)
   );

   // reference state
   bit [15:0] m_regs[NR];
   bit [7:0]  m_pkt[PB];
   bit [7:0]  m_hv[HB];

   logic [63:0] e_mkey = '0;
   logic [31:0] e_proto = '0;
   logic [3:0]  e_flags = '0;
   logic [15:0] e_alu = '0;
   logic [15:0] e_node = '0;
   logic        e_vld = 1'b0;
   logic        e_err = 1'b0;
   string       proto_tag = "R10";
   string       tag = "";

   int n_run = 0;
   int n_fail = 0;

   function automatic logic [7:0] pk(int i);
      return (i >= 0 && i < PB) ? m_pkt[i] : 8'h00;
   endfunction

   function automatic bit sbit(int p);
      if (p >= HB * 8) return 1'b0;
      return m_hv[p / 8][7 - (p % 8)];
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pack();
      for (int i = 0; i < NR; i++) regs_flat[i*16 +: 16] = m_regs[i];
      for (int i = 0; i < PB; i++) pkt_flat[i*8 +: 8] = m_pkt[i];
   endtask

   task automatic compare_all();
      chk("R1/R2/R3 match key", mkey, e_mkey);
      chk(proto_tag, pg_next_proto, e_proto);
      chk("R8 flags", pg_flags, e_flags);
      chk("R9 alu field", pg_alu_reg, e_alu);
      chk("R9 node field", pg_node, e_node);
      chk("R7/R10 valid", key_vld, e_vld);
      chk("R7 error", key_err, e_err);
   endtask

   // one clock: inputs already set at the falling edge
   task automatic step();
      int ho;
      int len;
      logic [31:0] ext;
      pack();
      if (start && np_op != 2'd3) begin
         ho = int'(m_regs[2]);
         for (int i = 0; i < KB - 1; i++) e_mkey[i*8 +: 8] = pk(ho + KB - 2 - i);
         e_mkey[63:56] = tsel_en ? m_regs[1][7:0] : prio;
         case (np_op)
            2'd0: begin
               len = (np_fb > 8'd32) ? 32 : int'(np_fb);
               ext = '0;
               for (int k = 0; k < len; k++) ext = {ext[30:0], sbit(int'(np_fa) + k)};
               e_proto = ext;
               proto_tag = "R4 extract";
            end
            2'd1: begin
               e_proto = {m_regs[np_fb[4:0]], m_regs[np_fa[4:0]]};
               proto_tag = "R5 build";
            end
            default: begin
               e_proto = '0;
               proto_tag = "R6 bypass";
            end
         endcase
         for (int n = 0; n < 4; n++) begin
            int fi;
            fi = int'(flag_idx[n*FIW +: FIW]);
            e_flags[n] = flag_en[n] ? m_regs[8 + fi / 16][fi % 16] : 1'b0;
         end
         e_alu  = m_regs[alu_idx];
         e_node = m_regs[3];
      end else begin
         proto_tag = "R10 hold";
      end
      if (tag != "") proto_tag = tag;
      e_vld = start && np_op != 2'd3;
      e_err = start && np_op == 2'd3;
      if (hv_load) begin
         for (int k = 0; k < HB; k++) m_hv[k] = pk(int'(m_regs[2]) + k);
      end
      @(posedge clk);
      #1;
      compare_all();
      @(negedge clk);
      tag = "";
   endtask

   task automatic round(logic [1:0] op, logic [7:0] fa, logic [7:0] fb);
      start = 1'b1; np_op = op; np_fa = fa; np_fb = fb;
      step();
      start = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) m_regs[i] = 16'($urandom);
      for (int i = 0; i < PB; i++) m_pkt[i] = 8'($urandom);
      for (int i = 0; i < HB; i++) m_hv[i] = 8'h00;
      m_regs[2] = 16'd0;
      pack();

      // R10: reset state
      repeat (3) @(posedge clk);
      #1;
      proto_tag = "R10 reset";
      compare_all();
      @(negedge clk);
      rst_n = 1'b1;

      // R11: load window at offset 0
      hv_load = 1'b1;
      step();
      hv_load = 1'b0;
      round(2'd0, 8'd0, 8'd8);                 // R4: first packet byte
      m_regs[2] = 16'd10;                      // offset moves, no reload
      tag = "R11 window kept";
      round(2'd0, 8'd0, 8'd8);
      hv_load = 1'b1; tag = "R11 same-edge old window";
      round(2'd0, 8'd4, 8'd12);
      hv_load = 1'b0;
      round(2'd0, 8'd13, 8'd20);               // R4: crosses word boundary
      round(2'd0, 8'd3, 8'd40);                // R4: length clamp
      round(2'd0, 8'd250, 8'd32);              // R4: past the window
      round(2'd0, 8'd7, 8'd0);                 // R4: zero length
      round(2'd1, 8'd5, 8'd7);                 // R5
      round(2'd2, 8'd9, 8'd9);                 // R6
      tsel_en = 1'b1; prio = 8'h5a;
      round(2'd2, 8'd0, 8'd0);                 // R1 register byte
      tsel_en = 1'b0;
      round(2'd2, 8'd0, 8'd0);                 // R1 priority byte
      m_regs[2] = 16'd60;  round(2'd1, 8'd1, 8'd2);   // R3 partial overrun
      m_regs[2] = 16'd300; round(2'd1, 8'd1, 8'd2);   // R3 full overrun
      hv_load = 1'b1; step(); hv_load = 1'b0;         // R3 window past end
      round(2'd0, 8'd0, 8'd32);
      round(2'd3, 8'd0, 8'd0);                 // R7 abort
      step();                                  // R10 idle hold
      flag_en = 4'b1010; flag_idx = {6'd63, 6'd17, 6'd32, 6'd0};
      m_regs[8] = 16'hffff; m_regs[9] = 16'h0002; m_regs[11] = 16'h8000;
      alu_idx = 5'd20;
      round(2'd2, 8'd0, 8'd0);                 // R8, R9

      // pseudo-random rounds
      for (int c = 0; c < 800; c++) begin
         if (c % 16 == 0) begin
            for (int i = 0; i < NR; i++) m_regs[i] = 16'($urandom);
            for (int i = 0; i < PB; i++) m_pkt[i] = 8'($urandom);
         end
         m_regs[2] = 16'($urandom_range(0, 80));
         start    = ($urandom_range(0, 9) < 7);
         hv_load  = ($urandom_range(0, 9) < 2);
         tsel_en  = 1'($urandom);
         prio     = 8'($urandom);
         np_op    = 2'($urandom);
         np_fa    = 8'($urandom);
         np_fb    = (np_op == 2'd0) ? 8'($urandom_range(0, 40)) : 8'($urandom);
         flag_en  = 4'($urandom);
         flag_idx = 24'($urandom);
         alu_idx  = 5'($urandom);
         step();
      end
      start = 1'b0; hv_load = 1'b0;
      step();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule